// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

The block sits between a single-request internal port and an external asynchronous static RAM of 65,536 sixteen-bit words. One request arrives as a strobe with a direction flag, an address, write data and a two-bit lane mask. The controller turns it into an active-low strobe sequence on the memory pins, with timing set by clock-count parameters. It then returns a one-clock completion strobe. For reads, that strobe comes with the merged read word.

A write asserts chip select, then lowers the write strobe for a programmable number of clocks, then raises it while address, lanes and data stay put for one more clock. A read lowers chip select and output enable for a programmable wait, then captures the bus. Lanes outside the mask come back as zero. After every read, one clock with all strobes high follows before anything else starts, so the controller never drives the shared bus while the memory may still be driving it. Whenever no transfer is under way, chip select stays high and the memory sits in standby.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, and on the first clock after it, every memory strobe is high, the bus driver is off and `rsp_ready` is low.
- R2: Chip select (`mem_ce_n`) is high whenever no transfer is in progress. A request is sampled only when the controller is idle, and a request strobe held high through a transfer starts nothing until the controller is idle again.
- R3: A write takes WR_PULSE+2 clocks with chip select low: one setup clock with the write strobe high, WR_PULSE clocks with `mem_we_n` low, and one hold clock with it high again. Through all of these, the data is driven (`mem_dq_oe` high) on `mem_dq_out` and does not change.
- R4: Address and lane enables stay constant for the whole time chip select is low. `mem_lb_n` is low exactly when mask bit 0 is set and covers data bits 7:0. `mem_ub_n` is low exactly when mask bit 1 is set and covers bits 15:8.
- R5: A read holds chip select and `mem_oe_n` low, with `mem_we_n` high and the bus driver off, for exactly RD_WAIT clocks. The bus is captured at the clock edge that ends the last of them.
- R6: In read data, a lane whose mask bit is clear returns zero. A lane whose mask bit is set returns the memory's byte.
- R7: `rsp_ready` is high for exactly one clock. For a write, that is the hold clock just after the write strobe rises. For a read, it is the clock after the capture edge, with `rsp_rdata` already valid and kept until the next read completes.
- R8: After a read, one clock with all strobes high follows before any next transfer. The bus driver is never on while output enable is low, nor in the clock that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, held until `rsp_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_ready | output | 1 | One-clock completion strobe |
| rsp_rdata | output | 16 | Merged read data |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
A sequencer stuck in or skipping a phase shows up as a wrong strobe level in the very clock it happens, because every pin is compared against a schedule derived from the requirements on every clock. A counter that is off by one stretches or shortens the write strobe or the read wait, and that is flagged at the first clock that differs. A lane register that is wrong shows either at once on the lane enables, or later, when a read of that word returns merged data that differs from the reference memory. A missing turnaround clock is caught both as a strobe mismatch and by a contention check between the driver and the modelled memory.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WSET  = 3'd1,
    ST_WLOW  = 3'd2,
    ST_WHOLD = 3'd3,
    ST_RWAIT = 3'd4,
    ST_RTURN = 3'd5
  } seq_state_e;

  function automatic logic st_selects(input seq_state_e s);
    return (s == ST_WSET) || (s == ST_WLOW) || (s == ST_WHOLD) || (s == ST_RWAIT);
  endfunction

  function automatic logic st_drives(input seq_state_e s);
    return (s == ST_WSET) || (s == ST_WLOW) || (s == ST_WHOLD);
  endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int WR_PULSE = 2,
  parameter int RD_WAIT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic load,
  output logic cap,
  output logic sel_d,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic drv,
  output logic ready
);

  localparam int MAXC = (WR_PULSE > RD_WAIT) ? WR_PULSE : RD_WAIT;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_e       st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ce_n_d, we_n_d, oe_n_d, drv_d, ready_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    load  = 1'b0;
    cap   = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        load = 1'b1;
        if (req_write) begin
          st_d = ST_WSET;
        end else begin
          st_d  = ST_RWAIT;
          cnt_d = CW'(RD_WAIT - 1);
        end
      end
      ST_WSET: begin
        st_d  = ST_WLOW;
        cnt_d = CW'(WR_PULSE - 1);
      end
      ST_WLOW: begin
        if (cnt_q == '0) st_d = ST_WHOLD;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_WHOLD: st_d = ST_IDLE;
      ST_RWAIT: begin
        if (cnt_q == '0) begin
          st_d = ST_RTURN;
          cap  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RTURN: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign sel_d   = st_selects(st_d);
  assign ce_n_d  = !sel_d;
  assign we_n_d  = (st_d != ST_WLOW);
  assign oe_n_d  = (st_d != ST_RWAIT);
  assign drv_d   = st_drives(st_d);
  assign ready_d = (st_d == ST_WHOLD) || (st_d == ST_RTURN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      drv   <= 1'b0;
      ready <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ce_n  <= ce_n_d;
      we_n  <= we_n_d;
      oe_n  <= oe_n_d;
      drv   <= drv_d;
      ready <= ready_d;
    end
  end

  // R2: idle means standby
  a_r2_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> ce_n);
  // R3: write strobe only inside a selected, non-reading cycle
  a_r3_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n));
  // R5: read phase never drives the bus
  a_r5_read_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!drv && we_n && !ce_n));
  // R8: driver stays off the clock after output enable
  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> !drv);
  // R7: completion strobe lasts one clock
  a_r7_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cap,
  input  logic              sel_d,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W/8-1:0] be_n,
  output logic [DATA_W-1:0] rdata
);

  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0]  mask_q, msel, be_n_d;
  logic [DATA_W-1:0] merged;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign msel[g]          = load ? req_mask[g] : mask_q[g];
    assign be_n_d[g]        = !(sel_d && msel[g]);
    assign merged[g*8 +: 8] = mask_q[g] ? dq_in[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      dq_out <= '0;
      mask_q <= '0;
      be_n   <= '1;
      rdata  <= '0;
    end else begin
      if (load) begin
        addr   <= req_addr;
        dq_out <= req_wdata;
        mask_q <= req_mask;
      end
      if (cap) rdata <= merged;
      be_n <= be_n_d;
    end
  end

  // R6: captured lanes outside the mask are zero
  a_r6_zero_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> ((rdata[7:0] == 8'h00) || mask_q[0]) && ((rdata[DATA_W-1:8] == '0) || (LANES < 2) || mask_q[LANES-1]));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int WR_PULSE = 2,
  parameter int RD_WAIT  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  input  logic [1:0]  req_mask,
  output logic        rsp_ready,
  output logic [15:0] rsp_rdata,
  output logic [15:0] mem_addr,
  output logic        mem_ce_n,
  output logic        mem_we_n,
  output logic        mem_oe_n,
  output logic        mem_lb_n,
  output logic        mem_ub_n,
  output logic [15:0] mem_dq_out,
  output logic        mem_dq_oe,
  input  logic [15:0] mem_dq_in
);

  logic       rst_meta, rst_s;
  logic       load, cap, sel_d;
  logic [1:0] be_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  sram_seq #(.WR_PULSE(WR_PULSE), .RD_WAIT(RD_WAIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s),
    .req_valid (req_valid),
    .req_write (req_write),
    .load      (load),
    .cap       (cap),
    .sel_d     (sel_d),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .drv       (mem_dq_oe),
    .ready     (rsp_ready)
  );

  sram_lane_dp #(.ADDR_W(16), .DATA_W(16)) u_dp (
    .clk       (clk),
    .rst_n     (rst_s),
    .load      (load),
    .cap       (cap),
    .sel_d     (sel_d),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .dq_in     (mem_dq_in),
    .addr      (mem_addr),
    .dq_out    (mem_dq_out),
    .be_n      (be_n),
    .rdata     (rsp_rdata)
  );

  assign mem_lb_n = be_n[0];
  assign mem_ub_n = be_n[1];

  // R4: address and lanes frozen while selected
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_s)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));
  // R4: lane enables only inside chip select
  a_r4_lanes_in_ce: assert property (@(posedge clk) disable iff (!rst_s)
    (!mem_lb_n || !mem_ub_n) |-> !mem_ce_n);
  // R3: data held and driven through the strobe's rising edge
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !mem_we_n |=> (mem_dq_oe && $stable(mem_dq_out) && !mem_ce_n));

endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
  localparam int P = 2;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic rsp_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out;
  logic [15:0] mem_dq_in = 16'hDEAD;

  always #4 clk = ~clk;

  sram_lane_ctrl #(.WR_PULSE(P), .RD_WAIT(W)) u0 (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0, cmp_on = 0;

  logic [15:0] sram [int];
  logic [15:0] refm [int];

  function automatic logic [15:0] rd_sram(input logic [15:0] a);
    return sram.exists(int'(a)) ? sram[int'(a)] : 16'h0000;
  endfunction
  function automatic logic [15:0] rd_ref(input logic [15:0] a);
    return refm.exists(int'(a)) ? refm[int'(a)] : 16'h0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference schedule
  bit busy = 0, kw = 0;
  int t = 0;
  logic [15:0] m_addr, m_data, exp_rdata = '0;
  logic [1:0]  m_mask;

  always @(posedge clk) begin
    if (!cmp_on) begin
      busy = 0;
    end else if (busy) begin
      t++;
      if (kw && t == P + 1) begin
        logic [15:0] o;
        o = rd_ref(m_addr);
        if (m_mask[0]) o[7:0]  = m_data[7:0];
        if (m_mask[1]) o[15:8] = m_data[15:8];
        refm[int'(m_addr)] = o;
      end
      if (!kw && t == W) begin
        logic [15:0] v;
        v = rd_ref(m_addr);
        exp_rdata = {m_mask[1] ? v[15:8] : 8'h00, m_mask[0] ? v[7:0] : 8'h00};
      end
      if ((kw && t == P + 2) || (!kw && t == W + 1)) busy = 0;
    end else if (req_valid) begin
      busy = 1; t = 0; kw = req_write;
      m_addr = req_addr; m_data = req_wdata; m_mask = req_mask;
    end
  end

  // memory model, bus modelling and per-clock comparison
  logic prev_we = 1'b1;
  always @(negedge clk) begin
    bit wact, ract, e_ce, e_we, e_oe, e_rdy, mem_drv;
    if (prev_we === 1'b0 && mem_we_n === 1'b1 && mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) begin
      logic [15:0] o;
      o = rd_sram(mem_addr);
      if (!mem_lb_n) o[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) o[15:8] = mem_dq_out[15:8];
      sram[int'(mem_addr)] = o;
    end
    prev_we = mem_we_n;
    mem_drv = (mem_ce_n === 1'b0) && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
    if (mem_drv) begin
      logic [15:0] v;
      v = rd_sram(mem_addr);
      mem_dq_in = {mem_ub_n ? 8'h5A : v[15:8], mem_lb_n ? 8'hA5 : v[7:0]};
    end else begin
      mem_dq_in = 16'hDEAD;
    end
    if (cmp_on) begin
      wact  = busy && kw && t <= P + 1;
      ract  = busy && !kw && t <= W - 1;
      e_ce  = !(wact || ract);
      e_we  = !(busy && kw && t >= 1 && t <= P);
      e_oe  = !ract;
      e_rdy = busy && ((kw && t == P + 1) || (!kw && t == W));
      chk(mem_ce_n === e_ce, "R2/R3/R5 ce_n", 16'(mem_ce_n), 16'(e_ce));
      chk(mem_we_n === e_we, "R3 we_n", 16'(mem_we_n), 16'(e_we));
      chk(mem_oe_n === e_oe, "R5 oe_n", 16'(mem_oe_n), 16'(e_oe));
      chk(mem_dq_oe === wact, "R3/R8 dq_oe", 16'(mem_dq_oe), 16'(wact));
      chk(mem_lb_n === !((wact || ract) && m_mask[0]), "R4 lb_n", 16'(mem_lb_n), 16'(!((wact || ract) && m_mask[0])));
      chk(mem_ub_n === !((wact || ract) && m_mask[1]), "R4 ub_n", 16'(mem_ub_n), 16'(!((wact || ract) && m_mask[1])));
      chk(rsp_ready === e_rdy, "R7 ready", 16'(rsp_ready), 16'(e_rdy));
      chk(!(mem_dq_oe === 1'b1 && mem_drv), "R8 contention", 16'(mem_dq_oe), 16'h0);
      if (!e_ce) chk(mem_addr === m_addr, "R4 addr", mem_addr, m_addr);
      if (wact)  chk(mem_dq_out === m_data, "R3 data", mem_dq_out, m_data);
      if (e_rdy && !kw) chk(rsp_rdata === exp_rdata, "R6 rdata", rsp_rdata, exp_rdata);
    end
  end

  task automatic xfer(input bit w, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m, input bit keep);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    do @(negedge clk); while (rsp_ready !== 1'b1);
    if (!keep) req_valid = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk(mem_ce_n === 1'b1 && mem_we_n === 1'b1 && mem_oe_n === 1'b1, "R1 strobes",
        {13'd0, mem_ce_n, mem_we_n, mem_oe_n}, 16'h0007);
    chk(mem_dq_oe === 1'b0 && rsp_ready === 1'b0, "R1 drv/ready", {14'd0, mem_dq_oe, rsp_ready}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n === 1'b1 && mem_dq_oe === 1'b0 && mem_lb_n === 1'b1 && mem_ub_n === 1'b1, "R1 after release",
        {12'd0, mem_ce_n, mem_dq_oe, mem_lb_n, mem_ub_n}, 16'h000B);
    repeat (3) @(negedge clk);
    cmp_on = 1;
    repeat (2) @(negedge clk);
    xfer(1, 16'h1234, 16'hBEEF, 2'b11, 0);   // R3 full write
    xfer(0, 16'h1234, 16'h0000, 2'b11, 0);   // R5 full read
    xfer(1, 16'h1234, 16'h00C3, 2'b01, 0);   // R4 lower lane only
    xfer(0, 16'h1234, 16'h0000, 2'b11, 0);   // R6 upper kept
    xfer(0, 16'h1234, 16'h0000, 2'b01, 0);   // R6 upper zero
    xfer(0, 16'h1234, 16'h0000, 2'b10, 0);   // R6 lower zero
    xfer(1, 16'h1234, 16'h7700, 2'b10, 0);   // R4 upper lane only
    xfer(0, 16'h1234, 16'h0000, 2'b11, 1);   // R8 read then held valid
    xfer(1, 16'hFFFF, 16'h5AA5, 2'b11, 1);   // R2 back-to-back
    xfer(1, 16'h0000, 16'h1111, 2'b11, 1);
    xfer(0, 16'hFFFF, 16'h0000, 2'b11, 1);
    xfer(0, 16'h0000, 16'h0000, 2'b10, 0);
    xfer(0, 16'h4321, 16'h0000, 2'b11, 0);   // unwritten word
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end
endmodule